// File: doc/BRIEF.md
# AXI Address Channel Rule Checker

This block watches one AXI address channel, either the write side or the read side, without driving it. In every cycle where VALID is high it evaluates the burst descriptor (start address, beat count, beat size, burst type, cache attributes and lock flag) against the encoding rules of the protocol. Each rule has its own error flag. A flag sets in the clock after a violating cycle and stays set until the active-low reset is asserted.

The checker is meant to sit beside a manager port or an interconnect input during bring-up or in the field. It adds no load to the handshake. The address width and the data bus width are parameters. The data bus width sets the largest legal beat size. A combined flag gives a single line to route to an interrupt or a debug register.

Top module: `axi_addr_rule_chk`

## Requirements
- R1: For an INCR burst (BURST = 2'b01), `err_page` sets when byte address ADDR + (LEN+1)·2^SIZE − 1 lies in a different 4096-byte page from ADDR. This includes a burst that runs past the top of the address space.
- R2: FIXED (2'b00) and WRAP (2'b10) bursts never set `err_page`, whatever their start address.
- R3: BURST = 2'b11 sets `err_burst_rsv`.
- R4: A WRAP burst whose ADDR is not a multiple of 2^SIZE sets `err_wrap_align`.
- R5: A WRAP burst whose LEN is not 1, 3, 7 or 15 (2, 4, 8 or 16 beats) sets `err_wrap_len`.
- R6: A FIXED burst with LEN above 15 sets `err_fixed_len`.
- R7: `err_size` sets when 2^SIZE bytes per beat exceeds DATA_W/8.
- R8: `err_cache` sets when CACHE[1] is 0 and CACHE[3:2] is not 2'b00. CACHE[0] has no influence.
- R9: `err_lock_len` sets when LOCK is 1 and LEN is above 15, for any burst type.
- R10: While VALID is low, no flag changes, whatever the other inputs hold. READY has no effect on any flag.
- R11: Flags are sticky. Further violations add to the set flags. Asserting `rst_n` low clears every flag at once.
- R12: `err_any` is high exactly when at least one individual flag is high.
- R13: A violation presented before a rising edge shows on the flags after that edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all flags |
| vld | input | 1 | Address channel VALID |
| rdy | input | 1 | Address channel READY (observed only) |
| addr | input | ADDR_W | Start address of the burst |
| len | input | 8 | Beat count minus one |
| size | input | 3 | Log2 of bytes per beat |
| burst | input | 2 | Burst type: 00 FIXED, 01 INCR, 10 WRAP, 11 reserved |
| cache | input | 4 | Memory attribute bits |
| lock | input | 1 | Exclusive access indicator |
| err_page | output | 1 | Sticky: INCR burst crossed a 4 KB page |
| err_burst_rsv | output | 1 | Sticky: reserved burst type seen |
| err_wrap_align | output | 1 | Sticky: misaligned WRAP start |
| err_wrap_len | output | 1 | Sticky: illegal WRAP length |
| err_fixed_len | output | 1 | Sticky: FIXED burst over 16 beats |
| err_size | output | 1 | Sticky: beat wider than the data bus |
| err_cache | output | 1 | Sticky: inconsistent cache attributes |
| err_lock_len | output | 1 | Sticky: exclusive burst over 16 beats |
| err_any | output | 1 | OR of all sticky flags |

## Verification
The hardest cases to reach are the edges of the page rule. One is a burst whose last byte falls exactly on the final byte of a page, which must stay clean, while one more beat must flag. The other is an INCR burst near the top of the address space whose end address wraps back to zero. The stimulus builds these from the start address, LEN and SIZE so that the end byte lands on each side of the boundary, including at address 0xFFFF_FFF0. A behavioural reference model runs alongside on every clock. Directed cases reset the flags between vectors, so each rule is seen on its own before several rules are triggered together to check that they accumulate.

// File: rtl/axi_chk_pkg.sv
package axi_chk_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'b00,
        BT_INCR  = 2'b01,
        BT_WRAP  = 2'b10,
        BT_RSVD  = 2'b11
    } burst_e;

    // Bit positions of the rule vector shared by the evaluator and the latch
    localparam int unsigned RULE_PAGE   = 0;
    localparam int unsigned RULE_RSVD   = 1;
    localparam int unsigned RULE_WALIGN = 2;
    localparam int unsigned RULE_WLEN   = 3;
    localparam int unsigned RULE_FLEN   = 4;
    localparam int unsigned RULE_SIZE   = 5;
    localparam int unsigned RULE_CACHE  = 6;
    localparam int unsigned RULE_LOCK   = 7;
    localparam int unsigned N_RULES     = 8;

    localparam int unsigned PAGE_BITS     = 12;
    localparam int unsigned LEN_W         = 8;
    localparam int unsigned SIZE_W        = 3;
    localparam int unsigned SHORT_LEN_MAX = 15;

endpackage

// File: rtl/axi_rule_eval.sv
module axi_rule_eval
    import axi_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64
) (
    input  logic                vld,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [LEN_W-1:0]    len,
    input  logic [SIZE_W-1:0]   size,
    input  logic [1:0]          burst,
    input  logic [3:0]          cache,
    input  logic                lock,
    output logic [N_RULES-1:0]  hit
);
    localparam int unsigned BUS_BYTES = DATA_W / 8;
    localparam int unsigned MAX_SIZE  = $clog2(BUS_BYTES);
    localparam int unsigned EXT_W     = ADDR_W + 1;
    localparam int unsigned SPAN_W    = 16;
    localparam int unsigned ALGN_W    = 7;

    burst_e              btype;
    logic [SPAN_W-1:0]   span_bytes;
    logic [EXT_W-1:0]    last_ext;
    logic [ALGN_W-1:0]   algn_mask;
    logic                page_diff;
    logic                wlen_ok;

    always_comb begin
        btype      = burst_e'(burst);
        span_bytes = ({{(SPAN_W-LEN_W){1'b0}}, len} + SPAN_W'(1)) << size;
        last_ext   = {1'b0, addr} + EXT_W'(span_bytes) - EXT_W'(1);
        page_diff  = last_ext[EXT_W-1:PAGE_BITS] != {1'b0, addr[ADDR_W-1:PAGE_BITS]};
        algn_mask  = ALGN_W'((8'd1 << size) - 8'd1);
        case (len)
            8'd1, 8'd3, 8'd7, 8'd15: wlen_ok = 1'b1;
            default:                 wlen_ok = 1'b0;
        endcase

        hit              = '0;
        hit[RULE_PAGE]   = (btype == BT_INCR) && page_diff;
        hit[RULE_RSVD]   = (btype == BT_RSVD);
        hit[RULE_WALIGN] = (btype == BT_WRAP) && ((addr[ALGN_W-1:0] & algn_mask) != '0);
        hit[RULE_WLEN]   = (btype == BT_WRAP) && !wlen_ok;
        hit[RULE_FLEN]   = (btype == BT_FIXED) && (int'(len) > SHORT_LEN_MAX);
        hit[RULE_SIZE]   = int'(size) > MAX_SIZE;
        hit[RULE_CACHE]  = !cache[1] && ((cache & 4'b1100) != 4'b0000);
        hit[RULE_LOCK]   = lock && (int'(len) > SHORT_LEN_MAX);
        if (!vld) begin
            hit = '0;
        end
    end

endmodule

// File: rtl/axi_err_latch.sv
module axi_err_latch #(
    parameter int unsigned N = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set,
    output logic [N-1:0]  flags
);
    typedef struct packed {
        logic [N-1:0] flags;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (set[i]) begin
                st_d.flags[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flags;

endmodule

// File: rtl/axi_addr_rule_chk.sv
module axi_addr_rule_chk
    import axi_chk_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld,
    input  logic              rdy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        len,
    input  logic [2:0]        size,
    input  logic [1:0]        burst,
    input  logic [3:0]        cache,
    input  logic              lock,
    output logic              err_page,
    output logic              err_burst_rsv,
    output logic              err_wrap_align,
    output logic              err_wrap_len,
    output logic              err_fixed_len,
    output logic              err_size,
    output logic              err_cache,
    output logic              err_lock_len,
    output logic              err_any
);
    logic [N_RULES-1:0] rule_hit;
    logic [N_RULES-1:0] flag_q;

    axi_rule_eval #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_eval (
        .vld   (vld),
        .addr  (addr),
        .len   (len),
        .size  (size),
        .burst (burst),
        .cache (cache),
        .lock  (lock),
        .hit   (rule_hit)
    );

    axi_err_latch #(
        .N (N_RULES)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (rule_hit),
        .flags (flag_q)
    );

    assign err_page       = flag_q[RULE_PAGE];
    assign err_burst_rsv  = flag_q[RULE_RSVD];
    assign err_wrap_align = flag_q[RULE_WALIGN];
    assign err_wrap_len   = flag_q[RULE_WLEN];
    assign err_fixed_len  = flag_q[RULE_FLEN];
    assign err_size       = flag_q[RULE_SIZE];
    assign err_cache      = flag_q[RULE_CACHE];
    assign err_lock_len   = flag_q[RULE_LOCK];
    assign err_any        = |flag_q;

    // R3: a reserved burst type presented with VALID shows up after the edge
    a_r3_rsvd_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && burst == 2'b11) |=> err_burst_rsv);

    // R8: inconsistent cache bits with VALID raise the cache flag
    a_r8_cache_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !cache[1] && cache[3:2] != 2'b00) |=> err_cache);

    // R6: long FIXED burst
    a_r6_fixed_len: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && burst == 2'b00 && len > 8'd15) |=> err_fixed_len);

    // R9: long exclusive burst
    a_r9_lock_len: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && lock && len > 8'd15) |=> err_lock_len);

    // R10: without VALID the flag set does not move
    a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !vld |=> $stable(flag_q));

    // R11: a completed handshake does not clear an error already recorded
    a_r11_keep_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && rdy && err_any) |=> err_any);

    // R11: no flag ever falls outside reset
    a_r11_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: tb/tb_axi_addr_rule_chk.sv
`timescale 1ns/100ps
module tb_axi_addr_rule_chk;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 64;

    localparam logic [7:0] M_PAGE = 8'h80;
    localparam logic [7:0] M_RSV  = 8'h40;
    localparam logic [7:0] M_WAL  = 8'h20;
    localparam logic [7:0] M_WLN  = 8'h10;
    localparam logic [7:0] M_FLN  = 8'h08;
    localparam logic [7:0] M_SIZ  = 8'h04;
    localparam logic [7:0] M_CAC  = 8'h02;
    localparam logic [7:0] M_LCK  = 8'h01;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              vld = 1'b0;
    logic              rdy = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        len = '0;
    logic [2:0]        size = '0;
    logic [1:0]        burst = 2'b01;
    logic [3:0]        cache = 4'b0011;
    logic              lock = 1'b0;
    logic err_page, err_burst_rsv, err_wrap_align, err_wrap_len;
    logic err_fixed_len, err_size, err_cache, err_lock_len, err_any;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit cmp_on = 0;
    logic [7:0] exp_q = '0;

    always #2.5 clk = ~clk;

    axi_addr_rule_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .vld(vld), .rdy(rdy), .addr(addr),
        .len(len), .size(size), .burst(burst), .cache(cache), .lock(lock),
        .err_page(err_page), .err_burst_rsv(err_burst_rsv),
        .err_wrap_align(err_wrap_align), .err_wrap_len(err_wrap_len),
        .err_fixed_len(err_fixed_len), .err_size(err_size),
        .err_cache(err_cache), .err_lock_len(err_lock_len), .err_any(err_any)
    );

    function automatic logic [7:0] act_vec();
        return {err_page, err_burst_rsv, err_wrap_align, err_wrap_len,
                err_fixed_len, err_size, err_cache, err_lock_len};
    endfunction

    function automatic string tag_of(input int b);
        case (b)
            7: return "R1";
            6: return "R3";
            5: return "R4";
            4: return "R5";
            3: return "R6";
            2: return "R7";
            1: return "R8";
            default: return "R9";
        endcase
    endfunction

    // Behavioural statement of the rules, straight from the requirements
    function automatic logic [7:0] rules(input logic [31:0] a, input logic [7:0] l,
                                         input logic [2:0] s, input logic [1:0] b,
                                         input logic [3:0] c, input logic k);
        longint unsigned beat = 64'd1 << s;
        longint unsigned first = a;
        longint unsigned last = first + (longint'(l) + 1) * beat - 1;
        logic [7:0] r = '0;
        if (b == 2'b01 && (first / 4096) != (last / 4096)) r |= M_PAGE;
        if (b == 2'b11) r |= M_RSV;
        if (b == 2'b10 && (first % beat) != 0) r |= M_WAL;
        if (b == 2'b10 && !(l == 1 || l == 3 || l == 7 || l == 15)) r |= M_WLN;
        if (b == 2'b00 && l > 15) r |= M_FLN;
        if (beat > DATA_W / 8) r |= M_SIZ;
        if (c[1] == 1'b0 && c[3:2] != 2'b00) r |= M_CAC;
        if (k && l > 15) r |= M_LCK;
        return r;
    endfunction

    // Reference model: sticky set of expected flags
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) exp_q <= '0;
        else if (vld) exp_q <= exp_q | rules(addr, len, size, burst, cache, lock);
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, expv, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int b = 0; b < 8; b++) begin
                check(tag_of(b), {7'd0, act_vec()[b]}, {7'd0, exp_q[b]});
            end
            check("R12", {7'd0, err_any}, {7'd0, |exp_q});
        end
    end

    task automatic do_reset();
        @(posedge clk); #1 rst_n = 1'b0; vld = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
    endtask

    task automatic drive(input logic [31:0] a, input logic [7:0] l, input logic [2:0] s,
                         input logic [1:0] b, input logic [3:0] c, input logic k);
        addr = a; len = l; size = s; burst = b; cache = c; lock = k; vld = 1'b1;
    endtask

    // One isolated vector: reset, present for one cycle, then check flags
    task automatic one_case(input string tag, input logic [31:0] a, input logic [7:0] l,
                            input logic [2:0] s, input logic [1:0] b, input logic [3:0] c,
                            input logic k, input logic [7:0] expv);
        do_reset();
        drive(a, l, s, b, c, k);
        rdy = ~rdy;
        @(posedge clk); #1 vld = 1'b0;
        @(negedge clk);
        check(tag, act_vec(), expv);
    endtask

    initial begin
        do_reset();
        cmp_on = 1;
        @(negedge clk);
        check("R11", act_vec(), 8'h00);
        check("R12", {7'd0, err_any}, 8'h00);

        one_case("R1",  32'h0000_0FF0, 8'd3,  3'd2, 2'b01, 4'b0011, 1'b0, 8'h00);
        one_case("R1",  32'h0000_0FF0, 8'd4,  3'd2, 2'b01, 4'b0011, 1'b0, M_PAGE);
        one_case("R1",  32'hFFFF_FFF0, 8'd3,  3'd2, 2'b01, 4'b0011, 1'b0, 8'h00);
        one_case("R1",  32'hFFFF_FFF0, 8'd4,  3'd2, 2'b01, 4'b0011, 1'b0, M_PAGE);
        one_case("R2",  32'h0000_0FFC, 8'd15, 3'd2, 2'b00, 4'b0011, 1'b0, 8'h00);
        one_case("R2",  32'h0000_0FF0, 8'd7,  3'd2, 2'b10, 4'b0011, 1'b0, 8'h00);
        one_case("R3",  32'h0000_0100, 8'd0,  3'd0, 2'b11, 4'b0011, 1'b0, M_RSV);
        one_case("R4",  32'h0000_0104, 8'd3,  3'd3, 2'b10, 4'b0011, 1'b0, M_WAL);
        one_case("R5",  32'h0000_0100, 8'd2,  3'd2, 2'b10, 4'b0011, 1'b0, M_WLN);
        one_case("R5",  32'h0000_0100, 8'd15, 3'd2, 2'b10, 4'b0011, 1'b0, 8'h00);
        one_case("R6",  32'h0000_0000, 8'd16, 3'd0, 2'b00, 4'b0011, 1'b0, M_FLN);
        one_case("R7",  32'h0000_0000, 8'd0,  3'd4, 2'b01, 4'b0011, 1'b0, M_SIZ);
        one_case("R7",  32'h0000_0000, 8'd0,  3'd3, 2'b01, 4'b0011, 1'b0, 8'h00);
        one_case("R8",  32'h0000_0000, 8'd0,  3'd0, 2'b01, 4'b0100, 1'b0, M_CAC);
        one_case("R8",  32'h0000_0000, 8'd0,  3'd0, 2'b01, 4'b1110, 1'b0, 8'h00);
        one_case("R8",  32'h0000_0000, 8'd0,  3'd0, 2'b01, 4'b0001, 1'b0, 8'h00);
        one_case("R9",  32'h0000_0000, 8'd16, 3'd0, 2'b01, 4'b0011, 1'b1, M_LCK);
        one_case("R9",  32'h0000_0000, 8'd15, 3'd0, 2'b01, 4'b0011, 1'b1, 8'h00);
        one_case("R12", 32'h0000_0FFC, 8'd20, 3'd5, 2'b11, 4'b1000, 1'b1,
                 M_RSV | M_SIZ | M_CAC | M_LCK);

        // R10: every field illegal, VALID low, READY toggling
        do_reset();
        addr = 32'h0000_0FFF; len = 8'd200; size = 3'd7; burst = 2'b11;
        cache = 4'b1100; lock = 1'b1; vld = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1 rdy = ~rdy;
        end
        @(negedge clk);
        check("R10", act_vec(), 8'h00);

        // R13: flags stay low before the sampling edge, rise after it
        do_reset();
        drive(32'h0, 8'd0, 3'd0, 2'b11, 4'b0011, 1'b0);
        @(negedge clk);
        check("R13", act_vec(), 8'h00);
        @(posedge clk); #1 vld = 1'b0;
        @(negedge clk);
        check("R13", act_vec(), M_RSV);

        // R11: held while idle, accumulates, cleared by reset
        for (int i = 0; i < 5; i++) @(posedge clk);
        @(negedge clk);
        check("R11", act_vec(), M_RSV);
        #1 drive(32'h0, 8'd0, 3'd0, 2'b01, 4'b0100, 1'b0);
        @(posedge clk); #1 vld = 1'b0;
        @(negedge clk);
        check("R11", act_vec(), M_RSV | M_CAC);
        #1 rst_n = 1'b0;
        #0.5;
        check("R11", act_vec(), 8'h00);
        @(posedge clk); #1 rst_n = 1'b1;

        // Mixed stream compared to the model each clock
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            drive(32'h0000_0F00 + 32'(i * 52), 8'(i * 7), 3'(i % 5), 2'(i % 4),
                  4'(i * 3), 1'(i % 3 == 0));
            vld = (i % 3 != 1);
            rdy = (i % 2 == 0);
        end
        @(posedge clk); #1 vld = 1'b0;
        @(negedge clk);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule